// File: doc/BRIEF.md
# DTMF Dual-Tone Staircase Sine Synthesizer

This block turns a row selection and a column selection from a keypad decoder into two digital sine sample streams and their sum. The block's clock is the 3.579545 MHz colour-burst reference. Each tone has its own chain. A fixed-divisor down-counter sets how many reference clocks each sine step lasts, and a 16-position step counter walks a quantized sine. The result is a staircase approximation of a sine wave, with 16 steps per period. The divisors are integers picked from a fixed table so that each output frequency lands within 0.75% of its standard DTMF frequency.

The column (high-group) tone is weighted 5/4 above the row (low-group) tone, which is about 1.94 dB of high-band pre-emphasis. The two signed samples are added into one wider signed word that goes to an external DAC. When a tone's valid input is low, its step counter is parked at phase zero, so that stream contributes zero (midscale) to the sum. A change of selection, or a valid bit that rises, reloads the divider and restarts the waveform at phase zero.

Top module: `dtmf_synth`

## Requirements
- R1: While reset is high, and on the first cycle after it, `row_smp`, `col_smp` and `sum_smp` are all zero.
- R2: The row divisor is 319, 290, 261 or 239 reference clocks per step for `row_sel` 0, 1, 2 or 3 (targets 697, 770, 852 and 941 Hz). While the row is valid, one full row waveform period lasts exactly 16 times the divisor.
- R3: The column divisor is 184, 168, 152 or 136 reference clocks per step for `col_sel` 0, 1, 2 or 3 (targets 1209, 1336, 1477 and 1633 Hz). One full column period lasts exactly 16 times the divisor.
- R4: Each period is a staircase of 16 steps, and every step changes the sample. The unit sine levels are 0, ±24, ±45, ±59 and ±64, and phase 0 is zero.
- R5: The row samples are the unit sine times 4 (peak ±256). The column samples are the unit sine times 5 (peak ±320), so the column peak is 5/4 of the row peak.
- R6: A tone whose valid input has been low for two consecutive clock edges outputs zero, and it stays at zero while the other tone runs.
- R7: `sum_smp` equals the signed sum of `row_smp` and `col_smp` from the previous cycle.
- R8: A new selection value, or a valid input that rises, restarts that tone at phase zero. The first positive sample appears after the restart edge plus the divisor plus 1 further clock edges, that is, on edge number divisor + 2 counting the restart edge as 1.
- R9: Each of the eight output frequencies, which is the reference divided by the measured period, is within ±0.75% of its target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 3.579545 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| row_sel | input | 2 | Low-group tone index 0..3 |
| row_vld | input | 1 | Row tone enable |
| col_sel | input | 2 | High-group tone index 0..3 |
| col_vld | input | 1 | Column tone enable |
| row_smp | output | SMP_W (10) | Signed row tone sample |
| col_smp | output | SMP_W (10) | Signed column tone sample |
| sum_smp | output | SMP_W+1 (11) | Signed sum of both samples, one cycle later |

## Verification
The hardest case to reach from the ports is a restart in the middle of a waveform. The selection must change while the step counter is at a random, non-zero phase, and the waveform must still come back exactly at phase zero with a freshly loaded divider. The bench reaches this case by letting a tone run for a random number of cycles taken from a seeded `$urandom`, and only then switching the selection or raising the valid bit. It then counts edges until the first positive step. Periods, step counts, peaks and the frequency error are measured on the rising zero crossings for all eight tones, taken in random order.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int unsigned STEP_BITS = 4;
    localparam int unsigned STEPS     = 1 << STEP_BITS;
    localparam int unsigned CNT_W     = 9;
    localparam int unsigned UNIT_W    = 8;
    localparam int unsigned UNIT_PEAK = 64;

    typedef enum logic {
        BAND_LOW  = 1'b0,
        BAND_HIGH = 1'b1
    } band_e;

    typedef struct packed {
        logic       vld;
        logic [1:0] sel;
    } tone_req_t;

    typedef logic [STEP_BITS-1:0] phase_t;
    typedef logic [CNT_W-1:0]     cnt_t;

    // Steps of reference clock per sine step, for each band and index
    function automatic cnt_t step_divisor(input band_e band, input logic [1:0] sel);
        cnt_t d;
        if (band == BAND_LOW) begin
            case (sel)
                2'd0:    d = cnt_t'(319);
                2'd1:    d = cnt_t'(290);
                2'd2:    d = cnt_t'(261);
                default: d = cnt_t'(239);
            endcase
        end else begin
            case (sel)
                2'd0:    d = cnt_t'(184);
                2'd1:    d = cnt_t'(168);
                2'd2:    d = cnt_t'(152);
                default: d = cnt_t'(136);
            endcase
        end
        return d;
    endfunction

    // Quarter-wave magnitude for offset 0..4 within a half period
    function automatic logic [UNIT_W-1:0] quarter_mag(input logic [2:0] m);
        logic [UNIT_W-1:0] v;
        case (m)
            3'd0:    v = 8'd0;
            3'd1:    v = 8'd24;
            3'd2:    v = 8'd45;
            3'd3:    v = 8'd59;
            default: v = 8'd64;
        endcase
        return v;
    endfunction

    // Signed unit sine at one of 16 phases, built by mirroring a quarter
    function automatic logic signed [UNIT_W-1:0] unit_sine(input phase_t k);
        logic [2:0]        m;
        logic [UNIT_W-1:0] mag;
        m   = k[2:0];
        mag = (m <= 3'd4) ? quarter_mag(m) : quarter_mag(3'd0 - m);
        return k[3] ? -$signed(mag) : $signed(mag);
    endfunction

endpackage

// File: rtl/tone_div.sv
module tone_div
    import dtmf_pkg::*;
#(
    parameter band_e BAND = BAND_LOW
) (
    input  logic      clk,
    input  logic      rst,
    input  tone_req_t req,
    output phase_t    phase
);

    tone_req_t req_q;
    cnt_t      cnt;
    cnt_t      reload;
    logic      restart;

    always_comb begin
        reload  = step_divisor(BAND, req.sel) - cnt_t'(1);
        restart = req.vld && (!req_q.vld || (req.sel != req_q.sel));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            cnt   <= '0;
            phase <= '0;
        end else begin
            req_q <= req;
            if (!req.vld) begin
                cnt   <= '0;
                phase <= '0;
            end else if (restart) begin
                cnt   <= reload;
                phase <= '0;
            end else if (cnt == '0) begin
                cnt   <= reload;
                phase <= phase + phase_t'(1);
            end else begin
                cnt   <= cnt - cnt_t'(1);
            end
        end
    end

endmodule

// File: rtl/sine_rom.sv
module sine_rom
    import dtmf_pkg::*;
#(
    parameter int unsigned GAIN  = 4,
    parameter int unsigned SMP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  phase_t                  phase,
    output logic signed [SMP_W-1:0] smp
);

    logic signed [UNIT_W-1:0] unit;
    logic signed [SMP_W-1:0]  unit_ext;
    logic signed [SMP_W-1:0]  scaled;

    always_comb begin
        unit     = unit_sine(phase);
        unit_ext = {{(SMP_W-UNIT_W){unit[UNIT_W-1]}}, unit};
        scaled   = unit_ext * $signed(SMP_W'(GAIN));
    end

    always_ff @(posedge clk) begin
        if (rst) smp <= '0;
        else     smp <= scaled;
    end

endmodule

// File: rtl/tone_sum.sv
module tone_sum #(
    parameter int unsigned SMP_W = 10,
    localparam int unsigned SUM_W = SMP_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] a,
    input  logic signed [SMP_W-1:0] b,
    output logic signed [SUM_W-1:0] y
);

    always_ff @(posedge clk) begin
        if (rst) y <= '0;
        else     y <= {a[SMP_W-1], a} + {b[SMP_W-1], b};
    end

endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
    import dtmf_pkg::*;
#(
    parameter int unsigned ROW_GAIN = 4,
    parameter int unsigned COL_GAIN = 5,
    parameter int unsigned SMP_W    = 10,
    localparam int unsigned SUM_W   = SMP_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              row_sel,
    input  logic                    row_vld,
    input  logic [1:0]              col_sel,
    input  logic                    col_vld,
    output logic signed [SMP_W-1:0] row_smp,
    output logic signed [SMP_W-1:0] col_smp,
    output logic signed [SUM_W-1:0] sum_smp
);

    localparam int unsigned NCH = 2;

    tone_req_t               req   [NCH];
    phase_t                  phase [NCH];
    logic signed [SMP_W-1:0] smp   [NCH];

    always_comb begin
        req[0] = '{vld: row_vld, sel: row_sel};
        req[1] = '{vld: col_vld, sel: col_sel};
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam band_e       CH_BAND = (g == 0) ? BAND_LOW : BAND_HIGH;
        localparam int unsigned CH_GAIN = (g == 0) ? ROW_GAIN : COL_GAIN;

        tone_div #(.BAND(CH_BAND)) u_div (
            .clk   (clk),
            .rst   (rst),
            .req   (req[g]),
            .phase (phase[g])
        );

        sine_rom #(.GAIN(CH_GAIN), .SMP_W(SMP_W)) u_rom (
            .clk   (clk),
            .rst   (rst),
            .phase (phase[g]),
            .smp   (smp[g])
        );
    end

    tone_sum #(.SMP_W(SMP_W)) u_sum (
        .clk (clk),
        .rst (rst),
        .a   (smp[0]),
        .b   (smp[1]),
        .y   (sum_smp)
    );

    assign row_smp = smp[0];
    assign col_smp = smp[1];

endmodule

// File: rtl/dtmf_synth_chk.sv
module dtmf_synth_chk #(
    parameter int unsigned ROW_GAIN = 4,
    parameter int unsigned COL_GAIN = 5,
    parameter int unsigned SMP_W    = 10,
    localparam int unsigned SUM_W   = SMP_W + 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    row_vld,
    input logic                    col_vld,
    input logic signed [SMP_W-1:0] row_smp,
    input logic signed [SMP_W-1:0] col_smp,
    input logic signed [SUM_W-1:0] sum_smp
);

    localparam int ROW_PK = 64 * ROW_GAIN;
    localparam int COL_PK = 64 * COL_GAIN;

    logic signed [SUM_W-1:0] row_ext;
    logic signed [SUM_W-1:0] col_ext;
    assign row_ext = {row_smp[SMP_W-1], row_smp};
    assign col_ext = {col_smp[SMP_W-1], col_smp};

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (sum_smp == '0 && row_smp == '0 && col_smp == '0));

    // R7
    sum_track_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sum_smp == ($past(row_ext) + $past(col_ext)));

    // R6
    row_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(row_vld) && !$past(row_vld, 2)) |-> row_smp == '0);

    // R6
    col_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(col_vld) && !$past(col_vld, 2)) |-> col_smp == '0);

    // R5
    row_peak_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(row_smp) <= ROW_PK) && (int'(row_smp) >= -ROW_PK));

    // R5
    col_peak_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(col_smp) <= COL_PK) && (int'(col_smp) >= -COL_PK));

endmodule

bind dtmf_synth dtmf_synth_chk #(
    .ROW_GAIN (ROW_GAIN),
    .COL_GAIN (COL_GAIN),
    .SMP_W    (SMP_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .row_vld (row_vld),
    .col_vld (col_vld),
    .row_smp (row_smp),
    .col_smp (col_smp),
    .sum_smp (sum_smp)
);

// File: tb/dtmf_synth_tb.sv
module dtmf_synth_tb;

    localparam int SMP_W = 10;
    localparam int SUM_W = SMP_W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] row_sel = '0;
    logic [1:0] col_sel = '0;
    logic row_vld = 1'b0;
    logic col_vld = 1'b0;
    logic signed [SMP_W-1:0] row_smp;
    logic signed [SMP_W-1:0] col_smp;
    logic signed [SUM_W-1:0] sum_smp;

    int errors = 0;
    int checks = 0;
    int sum_bad = 0;
    int sum_seen = 0;
    bit sum_on = 1'b0;
    int prev_row = 0;
    int prev_col = 0;

    always #2.5 clk = ~clk;

    dtmf_synth u_dut (
        .clk(clk), .rst(rst),
        .row_sel(row_sel), .row_vld(row_vld),
        .col_sel(col_sel), .col_vld(col_vld),
        .row_smp(row_smp), .col_smp(col_smp), .sum_smp(sum_smp)
    );

    function automatic int exp_div(input bit hi, input int idx);
        int lo_t[4] = '{319, 290, 261, 239};
        int hi_t[4] = '{184, 168, 152, 136};
        return hi ? hi_t[idx] : lo_t[idx];
    endfunction

    function automatic real exp_freq(input bit hi, input int idx);
        real lo_f[4] = '{697.0, 770.0, 852.0, 941.0};
        real hi_f[4] = '{1209.0, 1336.0, 1477.0, 1633.0};
        return hi ? hi_f[idx] : lo_f[idx];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int smp_of(input bit hi);
        return hi ? int'(col_smp) : int'(row_smp);
    endfunction

    // R7: compare the sum against the samples from one cycle earlier
    always @(negedge clk) begin
        if (sum_on) begin
            sum_seen++;
            if (int'(sum_smp) != prev_row + prev_col) sum_bad++;
        end
        prev_row = int'(row_smp);
        prev_col = int'(col_smp);
    end

    task automatic set_tone(input bit hi, input int idx, input bit v);
        if (hi) begin col_sel = idx[1:0]; col_vld = v; end
        else    begin row_sel = idx[1:0]; row_vld = v; end
    endtask

    // Measure one full period of one tone while the other is idle
    task automatic measure(input bit hi, input int idx);
        int d, pk, prev, cur, n, chg, mx, mn, other_nz;
        real f, dev;
        d  = exp_div(hi, idx);
        pk = 64 * (hi ? 5 : 4);
        @(negedge clk);
        set_tone(!hi, 0, 1'b0);
        set_tone(hi, idx, 1'b1);
        prev = 1;
        forever begin
            @(negedge clk);
            cur = smp_of(hi);
            if (prev <= 0 && cur > 0) break;
            prev = cur;
        end
        prev = cur; n = 0; chg = 0; mx = cur; mn = cur; other_nz = 0;
        forever begin
            @(negedge clk);
            n++;
            cur = smp_of(hi);
            if (cur != prev) chg++;
            if (cur > mx) mx = cur;
            if (cur < mn) mn = cur;
            if (smp_of(!hi) != 0) other_nz++;
            if (prev <= 0 && cur > 0) break;
            prev = cur;
        end
        if (hi) check(n == 16 * d, "R3 column period", n, 16 * d);
        else    check(n == 16 * d, "R2 row period", n, 16 * d);
        check(chg == 16, "R4 steps per period", chg, 16);
        check(mx == pk, "R5 positive peak", mx, pk);
        check(mn == -pk, "R5 negative peak", mn, -pk);
        check(other_nz == 0, "R6 idle tone stays zero", other_nz, 0);
        f   = 3579545.0 / real'(n);
        dev = (f - exp_freq(hi, idx)) / exp_freq(hi, idx);
        check(dev < 0.0075 && dev > -0.0075, "R9 frequency within 0.75%",
              int'(f), int'(exp_freq(hi, idx)));
    endtask

    // Edges from restart edge (counted as 1) until first positive sample
    task automatic restart_lat(input bit hi, input int idx, input string tag);
        int n, d;
        d = exp_div(hi, idx);
        set_tone(hi, idx, 1'b1);
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n >= 2 && smp_of(hi) > 0) break;
        end
        check(n == d + 2, tag, n, d + 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int order[8];
        void'($urandom(32'd5087));
        row_vld = 1'b1; col_vld = 1'b1;
        repeat (5) @(negedge clk);
        // R1: outputs zero during reset even with tones requested
        check(row_smp == 0 && col_smp == 0 && sum_smp == 0, "R1 reset zero",
              int'(sum_smp), 0);
        rst = 1'b0;
        row_vld = 1'b0; col_vld = 1'b0;
        @(negedge clk);
        check(row_smp == 0 && col_smp == 0 && sum_smp == 0, "R1 first cycle after reset",
              int'(row_smp), 0);
        sum_on = 1'b1;

        // All eight tones in random order
        for (int i = 0; i < 8; i++) order[i] = i;
        for (int i = 7; i > 0; i--) begin
            int j, t;
            j = $urandom_range(i, 0);
            t = order[i]; order[i] = order[j]; order[j] = t;
        end
        for (int i = 0; i < 8; i++) measure(order[i] >= 4, order[i] % 4);

        // R8: restart from idle via valid rising edge
        @(negedge clk);
        set_tone(1'b0, 0, 1'b0); set_tone(1'b1, 0, 1'b0);
        repeat (3) @(negedge clk);
        restart_lat(1'b0, 1, "R8 restart on valid rise");

        // R8: mid-waveform select change on the column, random phase
        for (int k = 0; k < 3; k++) begin
            int a, b;
            a = $urandom_range(3, 0);
            b = (a + 1 + $urandom_range(2, 0)) % 4;
            @(negedge clk);
            set_tone(1'b1, a, 1'b1);
            repeat ($urandom_range(2500, 200)) @(negedge clk);
            restart_lat(1'b1, b, "R8 restart on select change");
        end

        // R6: drop the row and check it returns to zero two edges later
        @(negedge clk);
        set_tone(1'b0, 2, 1'b0);
        repeat (3) @(negedge clk);
        check(row_smp == 0, "R6 row zero after valid low", int'(row_smp), 0);

        // R7: sum tracking across all activity above
        sum_on = 1'b0;
        check(sum_bad == 0 && sum_seen > 1000, "R7 sum of prior samples", sum_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule